// File: doc/BRIEF.md
# Dual-Port Parallel I/O Adapter

This block gives a CPU two 8-bit parallel ports, A and B, reached through a 2-bit register select. Each port has an output latch, a direction register and a control register. A route bit in each control register decides whether the port's data offset reaches the output latch or the direction register. Each pin is modelled as three separate signals: an input value, an output value and an output enable. Reading the data offset returns the live pin for input bits and the latch for output bits.

Each port has one interrupt input line, which is idle high. The line passes through a two-flop synchronizer, and a falling edge on it sets that port's status flag. Reading the port's data register clears the flag. The CPU interrupt request is the OR over both ports of status AND enable. Each port also has a control output line that follows one control bit. On port A this line is an active-low motor control, and on port B it is a command line.

Top module: `dual_port_io_adapter`

## Requirements
- R1: Synchronous active-high reset. After reset:
  - latches, direction registers, interrupt enables, route bits and status flags are all 0;
  - both control lines are 1;
  - irq is 0;
  - a control register reads 0x38.
- R2: The select codes map to registers as follows: 0 is port A data offset, 1 is port B data offset, 2 is control A, 3 is control B. A write takes effect at the next rising clock edge. rdata depends only on sel and the current state.
- R3: Route bit (control bit 2) selects what the data offset reaches. With route = 1, data-offset writes go to the output latch and reads return pin data. With route = 0, writes go to the direction register and reads return it.
- R4: Direction bit 1 makes the pin an output: oe = 1 and out = latch bit. A direction bit of 0 gives oe = 0. The out vector always shows the latch.
- R5: With route = 1, a data read returns (pin_in AND NOT dir) OR (latch AND dir).
- R6: A control write stores bit 0 (interrupt enable), bit 2 (route) and bit 3 (control line). Written bits 1, 4, 5, 6 and 7 have no effect. Control A bit 3 drives ctl_a (0 = motor on). Control B bit 3 drives ctl_b.
- R7: A control read returns {status, 0, 1, 1, line bit, route, 0, enable} from bit 7 down to bit 0.
- R8: A falling edge on a port's interrupt input sets its status at the third rising edge after the input goes low. A rising edge has no effect. The status is set even when the enable is 0.
- R9: A data-offset read with route = 1 clears that port's status. Reads with route = 0 and control reads leave it unchanged. A set and a clear in the same cycle leave the status set.
- R10: irq = (status_a AND enable_a) OR (status_b AND enable_b), taken from registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_in | input | 8 | Port A pin input values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin input values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| int_line_a | input | 1 | Port A interrupt input, idle high |
| int_line_b | input | 1 | Port B interrupt input, idle high |
| ctl_a | output | 1 | Port A motor line, active low |
| ctl_b | output | 1 | Port B command line |
| irq | output | 1 | Combined interrupt request, active high |

## Verification
The hardest case to reach is a status clear that lands on the same edge as a new synchronized falling edge. The read strobe has to be lined up with the third clock after the interrupt input drops. The bench drives the input low on a known falling clock edge. It counts two cycles and raises the read strobe for exactly the cycle in which the edge is detected. Random register traffic runs with fixed seeds and random pin values. It covers the route, direction and merge behaviour against a bench model.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int PORT_W   = 8;
    localparam int NPORTS   = 2;
    localparam int SEL_W    = 2;

    localparam int BIT_IEN   = 0;
    localparam int BIT_ROUTE = 2;
    localparam int BIT_LINE  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA_A = 2'd0,
        SEL_DATA_B = 2'd1,
        SEL_CTRL_A = 2'd2,
        SEL_CTRL_B = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic line;
        logic route;
        logic ien;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{line: 1'b1, route: 1'b0, ien: 1'b0};

    function automatic ctrl_t ctrl_from_byte(input logic [7:0] b);
        ctrl_t c;
        c.line  = b[BIT_LINE];
        c.route = b[BIT_ROUTE];
        c.ien   = b[BIT_IEN];
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input ctrl_t c, input logic status);
        return {status, 1'b0, 2'b11, c.line, c.route, 1'b0, c.ien};
    endfunction

    function automatic logic [PORT_W-1:0] merge_pins(
        input logic [PORT_W-1:0] pins,
        input logic [PORT_W-1:0] latch,
        input logic [PORT_W-1:0] dir
    );
        return (pins & ~dir) | (latch & dir);
    endfunction

endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], din};
        end
    end

    // chain_q[STAGES-1] is the synchronized level, chain_q[STAGES] its previous value
    assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/pio_port.sv
module pio_port
    import pio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_data,
    input  logic         wr_ctrl,
    input  logic         rd_data,
    input  logic [7:0]   wdata,
    input  logic [W-1:0] pin_in,
    input  logic         edge_fall,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] data_view,
    output logic [7:0]   ctrl_view,
    output logic         status,
    output logic         ien,
    output logic         route,
    output logic         line
);
    ctrl_t         ctrl_q;
    logic [W-1:0]  latch_q;
    logic [W-1:0]  dir_q;
    logic          status_q;
    logic          clear_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RESET;
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_from_byte(wdata);
            end
            if (wr_data) begin
                if (ctrl_q.route) begin
                    latch_q <= wdata[W-1:0];
                end else begin
                    dir_q <= wdata[W-1:0];
                end
            end
        end
    end

    assign clear_req = rd_data & ctrl_q.route;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= 1'b0;
        end else if (edge_fall) begin
            status_q <= 1'b1;
        end else if (clear_req) begin
            status_q <= 1'b0;
        end
    end

    assign pin_out   = latch_q;
    assign pin_oe    = dir_q;
    assign data_view = ctrl_q.route ? merge_pins(pin_in, latch_q, dir_q) : dir_q;
    assign ctrl_view = ctrl_to_byte(ctrl_q, status_q);
    assign status    = status_q;
    assign ien       = ctrl_q.ien;
    assign route     = ctrl_q.route;
    assign line      = ctrl_q.line;
endmodule

// File: rtl/dual_port_io_adapter.sv
module dual_port_io_adapter
    import pio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic              int_line_a,
    input  logic              int_line_b,
    output logic              ctl_a,
    output logic              ctl_b,
    output logic              irq
);
    logic [NPORTS-1:0][PORT_W-1:0] pin_in_v, pin_out_v, pin_oe_v, data_v;
    logic [NPORTS-1:0][7:0]        ctrl_v;
    logic [NPORTS-1:0]             line_in_v, fall_v, status_v, ien_v, route_v, line_v;
    logic [NPORTS-1:0]             wr_data_v, wr_ctrl_v, rd_data_v;

    assign pin_in_v  = {pb_in, pa_in};
    assign line_in_v = {int_line_b, int_line_a};

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        // sel[0] picks the port, sel[1] picks control vs data
        assign wr_data_v[p] = wr_en & ~sel[1] & (sel[0] == p[0]);
        assign wr_ctrl_v[p] = wr_en &  sel[1] & (sel[0] == p[0]);
        assign rd_data_v[p] = rd_en & ~sel[1] & (sel[0] == p[0]);

        pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (line_in_v[p]),
            .fall (fall_v[p])
        );

        pio_port #(.W(PORT_W)) u_port (
            .clk       (clk),
            .rst       (rst),
            .wr_data   (wr_data_v[p]),
            .wr_ctrl   (wr_ctrl_v[p]),
            .rd_data   (rd_data_v[p]),
            .wdata     (wdata),
            .pin_in    (pin_in_v[p]),
            .edge_fall (fall_v[p]),
            .pin_out   (pin_out_v[p]),
            .pin_oe    (pin_oe_v[p]),
            .data_view (data_v[p]),
            .ctrl_view (ctrl_v[p]),
            .status    (status_v[p]),
            .ien       (ien_v[p]),
            .route     (route_v[p]),
            .line      (line_v[p])
        );
    end

    always_comb begin
        unique case (reg_sel_e'(sel))
            SEL_DATA_A: rdata = data_v[0];
            SEL_DATA_B: rdata = data_v[1];
            SEL_CTRL_A: rdata = ctrl_v[0];
            default:    rdata = ctrl_v[1];
        endcase
    end

    assign pa_out = pin_out_v[0];
    assign pa_oe  = pin_oe_v[0];
    assign pb_out = pin_out_v[1];
    assign pb_oe  = pin_oe_v[1];
    assign ctl_a  = line_v[0];
    assign ctl_b  = line_v[1];
    assign irq    = |(status_v & ien_v);
endmodule

// File: rtl/pio_checker.sv
module pio_checker
    import pio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pa_oe,
    input logic              ctl_a,
    input logic              irq,
    input logic [NPORTS-1:0] status_v,
    input logic [NPORTS-1:0] ien_v,
    input logic [NPORTS-1:0] route_v,
    input logic [NPORTS-1:0] fall_v
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!irq && pa_oe == '0 && pa_out == '0 && ctl_a));

    p_dir_write_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == 2'd0 && !route_v[0]) |=> (pa_oe == $past(wdata)));

    p_latch_write_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == 2'd0 && route_v[0]) |=> (pa_out == $past(wdata)));

    p_line_write_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == 2'd2) |=> (ctl_a == $past(wdata[3])));

    p_fixed_bits_r7: assert property (@(posedge clk) disable iff (rst)
        sel[1] |-> (rdata[5:4] == 2'b11 && !rdata[6] && !rdata[1]));

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel == 2'd0 && route_v[0] && !fall_v[0]) |=> !status_v[0]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        fall_v[0] |=> status_v[0]);

    p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> |(ien_v & status_v));
endmodule

bind dual_port_io_adapter pio_checker u_pio_checker (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .pa_out   (pa_out),
    .pa_oe    (pa_oe),
    .ctl_a    (ctl_a),
    .irq      (irq),
    .status_v (status_v),
    .ien_v    (ien_v),
    .route_v  (route_v),
    .fall_v   (fall_v)
);

// File: tb/dual_port_io_adapter_bench.sv
module dual_port_io_adapter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe;
    logic       int_line_a = 1'b1, int_line_b = 1'b1;
    logic       ctl_a, ctl_b, irq;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic [7:0] m_latch [2];
    logic [7:0] m_dir   [2];
    logic       m_line  [2];
    logic       m_route [2];
    logic       m_ien   [2];
    logic       m_stat  [2];

    always #4 clk = ~clk;

    dual_port_io_adapter u_dual_port_io_adapter (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .int_line_a(int_line_a), .int_line_b(int_line_b),
        .ctl_a(ctl_a), .ctl_b(ctl_b), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_ctrl(input int p);
        return {m_stat[p], 1'b0, 2'b11, m_line[p], m_route[p], 1'b0, m_ien[p]};
    endfunction

    function automatic logic [7:0] exp_data(input int p, input logic [7:0] pins);
        if (m_route[p]) return (pins & ~m_dir[p]) | (m_latch[p] & m_dir[p]);
        return m_dir[p];
    endfunction

    function automatic logic exp_irq();
        return (m_stat[0] & m_ien[0]) | (m_stat[1] & m_ien[1]);
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 2; p++) begin
            m_latch[p] = 8'h00; m_dir[p] = 8'h00; m_line[p] = 1'b1;
            m_route[p] = 1'b0;  m_ien[p] = 1'b0;  m_stat[p] = 1'b0;
        end
    endtask

    // all tasks start and end just after a falling clock edge
    task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (s[1]) begin
            m_line[s[0]] = d[3]; m_route[s[0]] = d[2]; m_ien[s[0]] = d[0];
        end else if (m_route[s[0]]) begin
            m_latch[s[0]] = d;
        end else begin
            m_dir[s[0]] = d;
        end
    endtask

    task automatic read_reg(input logic [1:0] s, input string req);
        logic [7:0] exp;
        sel = s; rd_en = 1'b1;
        #1;
        exp = s[1] ? exp_ctrl(s[0]) : exp_data(s[0], s[0] ? pb_in : pa_in);
        check(req, rdata, exp);
        @(negedge clk);
        rd_en = 1'b0;
        if (!s[1] && m_route[s[0]]) m_stat[s[0]] = 1'b0;
    endtask

    task automatic peek_ctrl(input int p, input string req);
        sel = (p == 0) ? 2'd2 : 2'd3;
        #1;
        check(req, rdata, exp_ctrl(p));
    endtask

    task automatic check_pins(input string req);
        check({req, " pa_oe"},  pa_oe,  m_dir[0]);
        check({req, " pa_out"}, pa_out, m_latch[0]);
        check({req, " pb_oe"},  pb_oe,  m_dir[1]);
        check({req, " pb_out"}, pb_out, m_latch[1]);
        check({req, " ctl_a"},  ctl_a,  m_line[0]);
        check({req, " ctl_b"},  ctl_b,  m_line[1]);
        check({req, " irq"},    irq,    exp_irq());
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [1:0] s;
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_pins("R1");
        peek_ctrl(0, "R1 ctrl A");
        check("R1 ctrl A value", rdata, 8'h38);
        peek_ctrl(1, "R1 ctrl B");

        // R6: ignored bits 1,4-7 have no effect; R7 readback
        write_reg(2'd2, 8'hF6);
        peek_ctrl(0, "R6 ctrl A ignored bits");
        check("R6 ctl_a motor on", ctl_a, 1'b0);
        check("R7 ctrl A value", rdata, 8'h34);
        write_reg(2'd3, 8'h0C);
        check("R6 ctl_b", ctl_b, 1'b1);

        // R3/R4/R5 directed: port A route=1, direction 0xF0
        write_reg(2'd2, 8'h00);
        write_reg(2'd0, 8'hF0);           // direction (route 0)
        read_reg(2'd0, "R3 dir readback");
        write_reg(2'd2, 8'h04);
        write_reg(2'd0, 8'hA5);           // latch
        check("R4 pa_oe", pa_oe, 8'hF0);
        check("R4 pa_out", pa_out, 8'hA5);
        pa_in = 8'h3C;
        read_reg(2'd0, "R5 merge");
        check("R5 merge value", rdata, 8'hAC);

        // random register traffic (R2..R7, R10)
        for (int i = 0; i < 600; i++) begin
            pa_in = 8'($urandom); pb_in = 8'($urandom);
            s = 2'($urandom);
            if ($urandom % 2) write_reg(s, 8'($urandom));
            else read_reg(s, "R2 random read");
            check_pins("R4 random");
        end

        // interrupt directed: port A, enable 0, route 1
        write_reg(2'd2, 8'h04);
        write_reg(2'd3, 8'h04);
        int_line_a = 1'b0;
        @(negedge clk); @(negedge clk);
        peek_ctrl(0, "R8 not yet set after two edges");
        @(negedge clk);
        m_stat[0] = 1'b1;
        peek_ctrl(0, "R8 set on third edge");
        check("R8 status bit", rdata[7], 1'b1);
        check("R10 irq disabled", irq, 1'b0);
        write_reg(2'd2, 8'h05);
        check("R10 irq enabled", irq, 1'b1);
        int_line_a = 1'b1;
        repeat (4) @(negedge clk);
        peek_ctrl(0, "R8 rising edge no effect");
        read_reg(2'd2, "R9 ctrl read keeps status");
        peek_ctrl(0, "R9 status kept after ctrl read");
        write_reg(2'd2, 8'h01);           // route 0
        read_reg(2'd0, "R9 dir read");
        peek_ctrl(0, "R9 status kept after dir read");
        check("R10 irq still on", irq, 1'b1);
        write_reg(2'd2, 8'h05);
        read_reg(2'd0, "R9 data read");
        peek_ctrl(0, "R9 status cleared");
        check("R10 irq off after clear", irq, 1'b0);

        // set wins over clear in same cycle (R9)
        int_line_a = 1'b0;
        @(negedge clk); @(negedge clk);
        sel = 2'd0; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        m_stat[0] = 1'b1;
        peek_ctrl(0, "R9 set wins over clear");
        check("R9 irq after collision", irq, 1'b1);
        int_line_a = 1'b1;
        repeat (3) @(negedge clk);
        read_reg(2'd0, "R9 clear A");

        // port B interrupt, enabled (R8, R10)
        write_reg(2'd3, 8'h05);
        int_line_b = 1'b0;
        repeat (3) @(negedge clk);
        m_stat[1] = 1'b1;
        peek_ctrl(1, "R8 port B set");
        check("R10 irq from B", irq, 1'b1);
        read_reg(2'd1, "R9 port B data read");
        check("R10 irq B cleared", irq, 1'b0);
        int_line_b = 1'b1;
        repeat (3) @(negedge clk);

        // reset mid-run (R1)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        check_pins("R1 second reset");
        peek_ctrl(1, "R1 ctrl B after reset");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule